// File: doc/BRIEF.md
# Diminished-One Residue Arithmetic Unit (modulus 2^N+1)

This unit does arithmetic on residues modulo M = 2^N+1. Each operand arrives as an ordinary unsigned binary value from 0 to 2^N. It is recoded at once into a diminished form: an N-bit code word holding the value minus one, plus a separate flag that marks the value zero. All arithmetic is done on that form. The registered result is returned both in the internal form and as plain binary.

Four operations are offered. The unit can add or subtract two residues. It can scale one residue by any power of two, which becomes a rotation of the code word in which the bits that wrap around are complemented. It can also add three residues: a modular carry-save stage folds the three code words into two, with the inverted top carry fed back in at bit 0, and the modular adder then finishes the sum. A typical use is as the butterfly arithmetic of a multiplication-free number-theoretic transform, where every twiddle factor is a power of two.

Top module: `dimone_alu`

## Requirements
- R1: For every result, res_bin holds the residue value v in 0..2^N. When v is 0, res_zero is 1 and res_code is 0. Otherwise res_zero is 0 and res_code equals v-1.
- R2: With op = 2'b00, the result is (a + b) mod (2^N+1).
- R3: With op = 2'b01, the result is (a - b) mod (2^N+1), returned as a non-negative residue.
- R4: With op = 2'b10, the result is (a * 2^amt) mod (2^N+1) for every value of amt, including amounts of N and above.
- R5: With op = 2'b11, the result is (a + b + c) mod (2^N+1). This includes the cases where one or more of the three operands are zero.
- R6: In add or subtract, a zero second operand returns the first operand unchanged. A zero first operand returns the second operand, negated for subtract. Two zero operands give zero.
- R7: In scaling, a zero operand gives a zero result, and a non-zero operand always gives a non-zero result.
- R8: A request presented with in_valid high produces its result with out_valid high exactly one clock later. Cycles without a request give out_valid low and leave the result outputs unchanged.
- R9: While rst_n is low, and after it is released until the first request, out_valid, res_bin, res_code and res_zero are all 0.
- R10: Operand values on a_bin, b_bin and c_bin lie in 0..2^N whenever in_valid is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op | input | 2 | 00 add, 01 subtract, 10 scale by 2^amt, 11 three-operand add |
| amt | input | $clog2(2N) | Power-of-two exponent for scaling |
| a_bin | input | N+1 | First operand, binary 0..2^N |
| b_bin | input | N+1 | Second operand, binary 0..2^N |
| c_bin | input | N+1 | Third operand (three-operand add only) |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| res_bin | output | N+1 | Result as binary 0..2^N |
| res_code | output | N | Result code word (value minus one) |
| res_zero | output | 1 | Result is zero |

## Verification
The checker assumes that every operand presented with in_valid is a true residue no larger than 2^N. The value 2^N+1 and anything above it has no code word, and R10 holds the stimulus to that. The scoreboard draws operands only from 0..2^N and weights the draws toward 0, 1, 2^N and values near 2^(N-1), where the end-around corrections change sign. Shift amounts span the whole amt field, so the complementing half of the scaling range is covered. Idle gaps fall between requests, so the hold and strobe properties are exercised under the same stimulus.

// File: rtl/dimone_pkg.sv
package dimone_pkg;

   typedef enum logic [1:0] {
      OP_ADD   = 2'b00,
      OP_SUB   = 2'b01,
      OP_SCALE = 2'b10,
      OP_ADD3  = 2'b11
   } dimone_op_e;

endpackage

// File: rtl/dimone_enc.sv
// Binary residue (0..2^N) to diminished-one code word plus zero flag.
module dimone_enc #(
   parameter int N = 8
) (
   input  logic [N:0]   bin_i,
   output logic [N-1:0] code_o,
   output logic         zero_o
);
   logic [N-1:0] low_minus_one;

   // 2^N has low bits all zero, so subtracting one wraps to all ones
   assign low_minus_one = bin_i[N-1:0] - {{(N-1){1'b0}}, 1'b1};
   assign zero_o        = (bin_i == '0);
   assign code_o        = zero_o ? '0 : low_minus_one;
endmodule

// File: rtl/dimone_dec.sv
// Diminished-one code word plus zero flag back to binary residue.
module dimone_dec #(
   parameter int N = 8
) (
   input  logic [N-1:0] code_i,
   input  logic         zero_i,
   output logic [N:0]   bin_o
);
   assign bin_o = zero_i ? '0 : ({1'b0, code_i} + {{N{1'b0}}, 1'b1});
endmodule

// File: rtl/dimone_csa.sv
// Modular carry-save stage: three code words to a sum/carry pair.
// The carry leaving the top bit is inverted and re-entered at bit 0.
module dimone_csa #(
   parameter int N = 8
) (
   input  logic [N-1:0] x_i,
   input  logic [N-1:0] y_i,
   input  logic [N-1:0] w_i,
   output logic [N-1:0] sum_o,
   output logic [N-1:0] car_o
);
   logic [N-1:0] gen;

   for (genvar i = 0; i < N; i++) begin : g_fa
      assign sum_o[i] = x_i[i] ^ y_i[i] ^ w_i[i];
      assign gen[i]   = (x_i[i] & y_i[i]) | (x_i[i] & w_i[i]) | (y_i[i] & w_i[i]);
   end

   assign car_o = {gen[N-2:0], ~gen[N-1]};
endmodule

// File: rtl/dimone_add.sv
// Diminished-one modular adder with end-around inverted carry and
// zero-flag bypass.
module dimone_add #(
   parameter int N = 8
) (
   input  logic [N-1:0] d1_i,
   input  logic         z1_i,
   input  logic [N-1:0] d2_i,
   input  logic         z2_i,
   output logic [N-1:0] dr_o,
   output logic         zr_o
);
   logic [N:0]   raw;
   logic [N-1:0] low;
   logic         cout;
   logic [N-1:0] wrapped;
   logic         wrap_zero;

   assign raw       = {1'b0, d1_i} + {1'b0, d2_i};
   assign low       = raw[N-1:0];
   assign cout      = raw[N];
   assign wrapped   = low + {{(N-1){1'b0}}, ~cout};
   // no carry out and all ones below: sum hits the modulus exactly
   assign wrap_zero = ~cout & (&low);

   always_comb begin
      if (z1_i && z2_i) begin
         dr_o = '0;
         zr_o = 1'b1;
      end else if (z1_i) begin
         dr_o = d2_i;
         zr_o = 1'b0;
      end else if (z2_i) begin
         dr_o = d1_i;
         zr_o = 1'b0;
      end else begin
         dr_o = wrap_zero ? '0 : wrapped;
         zr_o = wrap_zero;
      end
   end
endmodule

// File: rtl/dimone_scale.sv
// Scaling by 2^amt: one stage per amount bit, stage j multiplies by
// 2^(2^j). The exponent is reduced mod 2N, because 2^N equals -1 mod 2^N+1.
// Each stage is a rotation whose wrapped bits are complemented,
// followed by a full complement when the reduced exponent reaches N.
module dimone_scale #(
   parameter int N  = 8,
   parameter int AW = 4
) (
   input  logic [N-1:0]  d_i,
   input  logic          z_i,
   input  logic [AW-1:0] amt_i,
   output logic [N-1:0]  dr_o,
   output logic          zr_o
);
   logic [N-1:0] stage [AW+1];

   assign stage[0] = d_i;

   for (genvar j = 0; j < AW; j++) begin : g_stage
      localparam int EXPM = (2 ** j) % (2 * N);
      localparam bit NEGT = (EXPM >= N);
      localparam int ROT  = NEGT ? (EXPM - N) : EXPM;

      logic [N-1:0] rot;
      logic [N-1:0] mul;

      for (genvar i = 0; i < N; i++) begin : g_bit
         if (i >= ROT) begin : g_keep
            assign rot[i] = stage[j][i-ROT];
         end else begin : g_wrap
            assign rot[i] = ~stage[j][i+N-ROT];
         end
      end

      if (NEGT) begin : g_neg
         assign mul = ~rot;
      end else begin : g_pos
         assign mul = rot;
      end

      assign stage[j+1] = amt_i[j] ? mul : stage[j];
   end

   assign dr_o = z_i ? '0 : stage[AW];
   assign zr_o = z_i;
endmodule

// File: rtl/dimone_alu.sv
module dimone_alu #(
   parameter int N  = 8,
   parameter int AW = $clog2(2 * N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [1:0]    op,
   input  logic [AW-1:0] amt,
   input  logic [N:0]    a_bin,
   input  logic [N:0]    b_bin,
   input  logic [N:0]    c_bin,
   output logic          out_valid,
   output logic [N:0]    res_bin,
   output logic [N-1:0]  res_code,
   output logic          res_zero
);
   import dimone_pkg::*;

   localparam int NOPS = 3;

   if (N < 2) begin : g_bad_n
      $error("dimone_alu: N must be at least 2");
   end
   if (AW < 1) begin : g_bad_aw
      $error("dimone_alu: AW must be at least 1");
   end

   dimone_op_e    op_e;
   logic [N:0]    bin_in  [NOPS];
   logic [N-1:0]  code_in [NOPS];
   logic          zero_in [NOPS];

   assign op_e      = dimone_op_e'(op);
   assign bin_in[0] = a_bin;
   assign bin_in[1] = b_bin;
   assign bin_in[2] = c_bin;

   for (genvar g = 0; g < NOPS; g++) begin : g_enc
      dimone_enc #(.N(N)) enc_i (
         .bin_i  (bin_in[g]),
         .code_o (code_in[g]),
         .zero_o (zero_in[g])
      );
   end

   // three-operand reduction
   logic [N-1:0] csa_sum, csa_car;

   dimone_csa #(.N(N)) csa_i (
      .x_i   (code_in[0]),
      .y_i   (code_in[1]),
      .w_i   (code_in[2]),
      .sum_o (csa_sum),
      .car_o (csa_car)
   );

   // adder operand steering
   logic [N-1:0] add_d1, add_d2;
   logic         add_z1, add_z2;

   always_comb begin
      add_d1 = code_in[0];
      add_z1 = zero_in[0];
      add_d2 = code_in[1];
      add_z2 = zero_in[1];
      unique case (op_e)
         OP_SUB: begin
            add_d2 = ~code_in[1];
         end
         OP_ADD3: begin
            if (zero_in[0]) begin
               add_d1 = code_in[1];
               add_z1 = zero_in[1];
               add_d2 = code_in[2];
               add_z2 = zero_in[2];
            end else if (zero_in[1]) begin
               add_d2 = code_in[2];
               add_z2 = zero_in[2];
            end else if (!zero_in[2]) begin
               add_d1 = csa_sum;
               add_z1 = 1'b0;
               add_d2 = csa_car;
               add_z2 = 1'b0;
            end
         end
         default: ;
      endcase
   end

   logic [N-1:0] add_dr;
   logic         add_zr;

   dimone_add #(.N(N)) add_i (
      .d1_i (add_d1),
      .z1_i (add_z1),
      .d2_i (add_d2),
      .z2_i (add_z2),
      .dr_o (add_dr),
      .zr_o (add_zr)
   );

   logic [N-1:0] scl_dr;
   logic         scl_zr;

   dimone_scale #(.N(N), .AW(AW)) scale_i (
      .d_i   (code_in[0]),
      .z_i   (zero_in[0]),
      .amt_i (amt),
      .dr_o  (scl_dr),
      .zr_o  (scl_zr)
   );

   logic [N-1:0] nxt_code;
   logic         nxt_zero;

   assign nxt_code = (op_e == OP_SCALE) ? scl_dr : add_dr;
   assign nxt_zero = (op_e == OP_SCALE) ? scl_zr : add_zr;

   logic [N-1:0] q_code;
   logic         q_zero;
   logic         q_valid;
   logic         q_any;

   // q_any keeps the reset-state outputs at zero until a first result
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
         q_code  <= '0;
         q_zero  <= 1'b0;
         q_any   <= 1'b0;
      end else begin
         q_valid <= in_valid;
         if (in_valid) begin
            q_code <= nxt_code;
            q_zero <= nxt_zero;
            q_any  <= 1'b1;
         end
      end
   end

   logic [N:0] dec_bin;

   dimone_dec #(.N(N)) dec_i (
      .code_i (q_code),
      .zero_i (q_zero),
      .bin_o  (dec_bin)
   );

   assign out_valid = q_valid;
   assign res_code  = q_code;
   assign res_zero  = q_zero;
   assign res_bin   = q_any ? dec_bin : '0;
endmodule

// File: rtl/dimone_alu_chk.sv
module dimone_alu_chk #(
   parameter int N  = 8,
   parameter int AW = $clog2(2 * N)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic [1:0]    op,
   input logic [AW-1:0] amt,
   input logic [N:0]    a_bin,
   input logic [N:0]    b_bin,
   input logic [N:0]    c_bin,
   input logic          out_valid,
   input logic [N:0]    res_bin,
   input logic [N-1:0]  res_code,
   input logic          res_zero
);
   localparam logic [N:0] TOPV = {1'b1, {N{1'b0}}};

   AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (a_bin <= TOPV && b_bin <= TOPV && c_bin <= TOPV)); // R10

   AST_OUT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      res_bin <= TOPV); // R1

   AST_ZERO_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && res_zero) |-> (res_code == '0 && res_bin == '0)); // R1

   AST_CODE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !res_zero) |-> (res_bin == {1'b0, res_code} + 1'b1)); // R1

   AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R8

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(res_bin) && $stable(res_code)
                     && $stable(res_zero))); // R8

   AST_ADD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 2'b00 && b_bin == '0) |=> (res_bin == $past(a_bin))); // R6

   AST_SCALE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 2'b10 && a_bin == '0) |=> res_zero); // R7

   AST_SCALE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 2'b10 && a_bin != '0) |=> !res_zero); // R7

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && res_bin == '0 && !res_zero)); // R9
endmodule

bind dimone_alu dimone_alu_chk #(.N(N), .AW(AW)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op        (op),
   .amt       (amt),
   .a_bin     (a_bin),
   .b_bin     (b_bin),
   .c_bin     (c_bin),
   .out_valid (out_valid),
   .res_bin   (res_bin),
   .res_code  (res_code),
   .res_zero  (res_zero)
);

// File: tb/dimone_alu_tb_top.sv
module dimone_alu_tb_top;
   localparam int N    = 8;
   localparam int AW   = $clog2(2 * N);
   localparam int MODV = (1 << N) + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [1:0]    op = '0;
   logic [AW-1:0] amt = '0;
   logic [N:0]    a_bin = '0, b_bin = '0, c_bin = '0;
   logic          out_valid;
   logic [N:0]    res_bin;
   logic [N-1:0]  res_code;
   logic          res_zero;

   int n_checks = 0;
   int n_fail   = 0;
   int exp_q [$];
   string req_q [$];
   int last_exp = 0;
   int n_results = 0;
   int n_pushed = 0;

   always #4 clk = ~clk;   // 125 MHz

   dimone_alu #(.N(N), .AW(AW)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .op        (op),
      .amt       (amt),
      .a_bin     (a_bin),
      .b_bin     (b_bin),
      .c_bin     (c_bin),
      .out_valid (out_valid),
      .res_bin   (res_bin),
      .res_code  (res_code),
      .res_zero  (res_zero)
   );

   task automatic check(input bit ok, input string req, input int act, input int expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   function automatic int ref_result(input int o, input int k, input int a, input int b, input int c);
      int p;
      p = 1;
      case (o)
         0: return (a + b) % MODV;                 // R2
         1: return (a - b + MODV) % MODV;          // R3
         2: begin                                  // R4
            for (int i = 0; i < k; i++) p = (p * 2) % MODV;
            return (a * p) % MODV;
         end
         default: return (a + b + c) % MODV;       // R5
      endcase
   endfunction

   task automatic drive(input int o, input int k, input int a, input int b, input int c, input string req);
      @(negedge clk);
      op       = o[1:0];
      amt      = k[AW-1:0];
      a_bin    = a[N:0];
      b_bin    = b[N:0];
      c_bin    = c[N:0];
      in_valid = 1'b1;
      exp_q.push_back(ref_result(o, k, a, b, c));
      req_q.push_back(req);
      n_pushed++;
   endtask

   task automatic idle(input int cycles);
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   function automatic int pick_val();
      int r;
      r = $urandom_range(0, 9);
      case (r)
         0: return 0;
         1: return 1;
         2: return 1 << N;
         3: return (1 << (N - 1)) + $urandom_range(0, 2) - 1;
         default: return $urandom_range(0, 1 << N);
      endcase
   endfunction

   // monitor: pops the scoreboard as results appear
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (rst_n && out_valid) begin
            n_results++;
            if (exp_q.size() == 0) begin
               check(1'b0, "R8 unexpected out_valid", 1, 0);
            end else begin
               int e;
               string rq;
               e  = exp_q.pop_front();
               rq = req_q.pop_front();
               last_exp = e;
               check(int'(res_bin) == e, rq, int'(res_bin), e);
               check(res_zero == (e == 0), "R1 zero flag", int'(res_zero), int'(e == 0));
               check(int'(res_code) == ((e == 0) ? 0 : e - 1), "R1 code word",
                     int'(res_code), (e == 0) ? 0 : e - 1);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      check(out_valid == 1'b0 && res_bin == '0 && res_zero == 1'b0, "R9 in reset", int'(res_bin), 0);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(out_valid == 1'b0 && res_bin == '0 && res_code == '0, "R9 after release", int'(res_bin), 0);

      // directed corners
      drive(0, 0, 256, 256, 0, "R2 top+top");
      drive(0, 0, 1, 256, 0, "R2 sum to modulus");
      drive(0, 0, 128, 129, 0, "R2 mid wrap to zero");
      drive(0, 0, 200, 100, 0, "R2 wrap");
      drive(0, 0, 77, 0, 0, "R6 add b zero");
      drive(0, 0, 0, 91, 0, "R6 add a zero");
      drive(0, 0, 0, 0, 0, "R6 add both zero");
      drive(1, 0, 0, 1, 0, "R3 zero minus one");
      drive(1, 0, 150, 150, 0, "R3 equal operands");
      drive(1, 0, 5, 0, 0, "R6 sub b zero");
      drive(1, 0, 0, 40, 0, "R6 sub a zero");
      drive(1, 0, 3, 256, 0, "R3 minus top");
      idle(2);
      drive(2, 8, 1, 0, 0, "R4 one by 2^8");
      drive(2, 9, 1, 0, 0, "R4 one by 2^9");
      drive(2, 1, 256, 0, 0, "R4 top doubled");
      drive(2, 15, 200, 0, 0, "R4 max amount");
      drive(2, 0, 123, 0, 0, "R4 amount zero");
      drive(2, 5, 0, 0, 0, "R7 scale zero");
      drive(2, 7, 129, 0, 0, "R7 scale nonzero");
      drive(3, 0, 256, 256, 256, "R5 three tops");
      drive(3, 0, 0, 10, 20, "R5 a zero");
      drive(3, 0, 10, 0, 20, "R5 b zero");
      drive(3, 0, 10, 20, 0, "R5 c zero");
      drive(3, 0, 0, 0, 0, "R5 all zero");
      drive(3, 0, 100, 100, 57, "R5 sum to modulus");
      idle(3);
      check(out_valid == 1'b0, "R8 idle strobe", int'(out_valid), 0);
      check(int'(res_bin) == last_exp, "R8 hold after idle", int'(res_bin), last_exp);

      // random stream with gaps
      for (int i = 0; i < 600; i++) begin
         int o;
         string rq;
         o = $urandom_range(0, 3);
         case (o)
            0: rq = "R2 random add";
            1: rq = "R3 random sub";
            2: rq = "R4 random scale";
            default: rq = "R5 random add3";
         endcase
         drive(o, $urandom_range(0, 2 * N - 1), pick_val(), pick_val(), pick_val(), rq);
         if ($urandom_range(0, 5) == 0) idle($urandom_range(1, 3));
      end
      idle(4);
      check(exp_q.size() == 0, "R8 all results returned", exp_q.size(), 0);
      check(n_results == n_pushed, "R8 result count", n_results, n_pushed);
      check(int'(res_bin) == last_exp, "R8 final hold", int'(res_bin), last_exp);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule